// File: doc/BRIEF.md
# Wake-up and Kickstart Power Sequencer

This block is the power-control logic of a real-time clock. It switches the system supply on and off through an active-low, open-drain power-enable output. The output is modelled as an enable plus a level, and the level is always low. While the system is off, two events can start a power-on attempt. One is a kickstart, a sufficiently long low pulse on an active-low pin. The other is a wake, a strobe from the alarm comparator that says the stored date and time match the current time. Each event is gated by its own enable bit.

A power-on attempt holds the power-enable output active and counts timebase ticks. If the supply-valid comparator asserts before the count runs out, the sequencer reaches the powered state. It clears the power-off bit and drives the open-drain interrupt output to report the flag that caused the power-on. If the count runs out first, both outputs go back to high impedance. The flag that started the attempt stays latched so that software can see it after a later successful power-on. Software powers the system down by writing 1 to the power-off bit.

The state machine has three states. OFF covers power down, with both outputs released. ATTEMPT covers the timeout window, with power driven and the interrupt released. ON covers power applied, where the interrupt is driven whenever a pending condition exists. The transitions are as follows:
- START: OFF to ATTEMPT, on an enabled kickstart or an enabled wake.
- GOOD: ATTEMPT to ON, when the supply is valid.
- EXPIRE: ATTEMPT to OFF, when the timeout expires without a valid supply.
- SHUTDOWN: ON to OFF, when the power-off bit is 1.

Top module: `wake_power_seq`

## Requirements
- R1: After reset the state is OFF, `pwr_oe_o`=0, `irq_oe_o`=0 and `flags_o`=2'b00. The enables and the power-off bit are 0.
- R2: A kickstart counts only when the synchronized `kick_n_i` was high, then stays low for at least MIN_KS_TICKS cycles in which `tick_i`=1. A shorter low period, or one without ticks, is ignored. Each low period counts at most once.
- R3: A counted kickstart sets the kick flag (`flags_o[1]`) and starts an attempt from OFF, but only when the kick enable (`ctl_wdata_i[1]`) is 1. With the enable at 0 it has no effect.
- R4: An `alarm_match_i` strobe always sets the wake flag (`flags_o[0]`). It starts an attempt from OFF only when the wake enable (`ctl_wdata_i[0]`) is 1.
- R5: In ATTEMPT, `pwr_oe_o`=1 with `pwr_lvl_o`=0, and `irq_oe_o`=0.
- R6: If `supply_ok_i` stays 0 for TIMEOUT_TICKS ticks in ATTEMPT, the block returns to OFF with `pwr_oe_o`=0 and `irq_oe_o`=0.
- R7: A failed attempt leaves both flags unchanged. A flag clears only through a flag write (`flag_wr_i`) that carries 0 in its bit; a 1 in a bit leaves that flag as it is. A set event in the same cycle wins over a clear.
- R8: `supply_ok_i`=1 in ATTEMPT moves the block to ON and clears the power-off bit (`ctl_wdata_i[2]`). In ON, `pwr_oe_o` stays 1 while the power-off bit is 0.
- R9: In ON, `irq_oe_o` is 1 exactly when an enabled flag is set or `other_irq_i` is 1. Outside ON it is 0.
- R10: A control write (`ctl_wr_i`, fields wake enable bit 0, kick enable bit 1, power-off bit 2) with bit 2 set drops `pwr_oe_o` in the next cycle. The block goes to OFF in the cycle after that.
- R11: When the supply is already valid while the block is in OFF, an enabled event still asserts the power-enable output, and the block reaches ON through ATTEMPT. Events in ON set their flags and raise the interrupt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Timebase tick, one-cycle strobe |
| kick_n_i | input | 1 | Asynchronous active-low kickstart pin |
| alarm_match_i | input | 1 | Alarm date/time match strobe |
| supply_ok_i | input | 1 | Main supply valid comparator |
| other_irq_i | input | 1 | Other pending interrupt sources of the clock |
| ctl_wr_i | input | 1 | Control register write strobe |
| ctl_wdata_i | input | 3 | Control data: [0] wake enable, [1] kick enable, [2] power-off |
| flag_wr_i | input | 1 | Flag register write strobe |
| flag_wdata_i | input | 2 | Flag data: a 0 clears [0] wake flag, [1] kick flag |
| pwr_oe_o | output | 1 | Power-enable output driver enable (1 = pin driven) |
| pwr_lvl_o | output | 1 | Power-enable output level when driven (always 0) |
| irq_oe_o | output | 1 | Interrupt open-drain driver enable (1 = pin driven low) |
| flags_o | output | 2 | Flag readback: [0] wake, [1] kick |

## Verification
The bench builds the block with MIN_KS_TICKS=4, TIMEOUT_TICKS=16 and two synchronizer stages, and holds the tick high in most sequences. With these values, the pulse-width boundary at three and four cycles can be reached in a few dozen cycles. So can a complete timeout window, including points just inside and just past its end. One sequence holds the tick low during a long pulse to show that the width is measured in ticks and not in clock cycles.

// File: rtl/wpc_pkg.sv
package wpc_pkg;

    typedef enum logic [1:0] {
        ST_OFF     = 2'd0,
        ST_ATTEMPT = 2'd1,
        ST_ON      = 2'd2
    } seq_state_t;

    localparam int CTL_WAKE_EN = 0;
    localparam int CTL_KICK_EN = 1;
    localparam int CTL_PWR_OFF = 2;
    localparam int CTL_W       = 3;

    localparam int FLG_WAKE = 0;
    localparam int FLG_KICK = 1;
    localparam int FLG_W    = 2;

endpackage

// File: rtl/wpc_sync.sv
module wpc_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] pipe_q;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe_q[g] <= RST_VAL;
                else        pipe_q[g] <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe_q[g] <= RST_VAL;
                else        pipe_q[g] <= pipe_q[g-1];
            end
        end
    end

    assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/wpc_kick_detect.sv
module wpc_kick_detect #(
    parameter int MIN_TICKS   = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic kick_n_i,
    output logic fire_o
);
    localparam int CW = $clog2(MIN_TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(MIN_TICKS - 1);

    logic          line_s;
    logic          armed_q;
    logic [CW-1:0] width_q;

    wpc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (kick_n_i),
        .q_o   (line_s)
    );

    assign fire_o = armed_q && !line_s && tick_i && (width_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            width_q <= '0;
        end else if (line_s) begin
            armed_q <= 1'b1;
            width_q <= '0;
        end else if (fire_o) begin
            armed_q <= 1'b0;
            width_q <= '0;
        end else if (armed_q && tick_i) begin
            width_q <= width_q + 1'b1;
        end
    end

    // R2
    single_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |=> !fire_o);
endmodule

// File: rtl/wpc_tick_timer.sv
module wpc_tick_timer #(
    parameter int LIMIT = 2048
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic tick_i,
    output logic hit_o
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    assign hit_o = run_i && tick_i && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 cnt_q <= '0;
        else if (!run_i || hit_o)   cnt_q <= '0;
        else if (tick_i)            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/wake_power_seq.sv
module wake_power_seq
    import wpc_pkg::*;
#(
    parameter int MIN_KS_TICKS  = 8,
    parameter int TIMEOUT_TICKS = 2048,
    parameter int SYNC_STAGES   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             kick_n_i,
    input  logic             alarm_match_i,
    input  logic             supply_ok_i,
    input  logic             other_irq_i,
    input  logic             ctl_wr_i,
    input  logic [CTL_W-1:0] ctl_wdata_i,
    input  logic             flag_wr_i,
    input  logic [FLG_W-1:0] flag_wdata_i,
    output logic             pwr_oe_o,
    output logic             pwr_lvl_o,
    output logic             irq_oe_o,
    output logic [FLG_W-1:0] flags_o
);
    seq_state_t st_q, st_d;
    logic       wake_en_q, kick_en_q, pwr_off_q;
    logic       wake_flag_q, kick_flag_q;
    logic       ks_fire, kick_go, wake_go, start_req, tmo_hit, power_good;

    wpc_kick_detect #(.MIN_TICKS(MIN_KS_TICKS), .SYNC_STAGES(SYNC_STAGES)) u_kick (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick_i),
        .kick_n_i (kick_n_i),
        .fire_o   (ks_fire)
    );

    wpc_tick_timer #(.LIMIT(TIMEOUT_TICKS)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (st_q == ST_ATTEMPT),
        .tick_i (tick_i),
        .hit_o  (tmo_hit)
    );

    assign kick_go    = ks_fire && kick_en_q;
    assign wake_go    = alarm_match_i && wake_en_q;
    assign start_req  = kick_go || wake_go;
    assign power_good = (st_q == ST_ATTEMPT) && supply_ok_i;

    // next-state logic: START, GOOD, EXPIRE, SHUTDOWN
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_OFF:     if (start_req) st_d = ST_ATTEMPT;
            ST_ATTEMPT: begin
                if (supply_ok_i)  st_d = ST_ON;
                else if (tmo_hit) st_d = ST_OFF;
            end
            ST_ON:      if (pwr_off_q) st_d = ST_OFF;
            default:    st_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_OFF;
        else        st_q <= st_d;
    end

    // control bits: software load, hardware clear of power-off on GOOD
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wake_en_q <= 1'b0;
            kick_en_q <= 1'b0;
            pwr_off_q <= 1'b0;
        end else if (ctl_wr_i) begin
            wake_en_q <= ctl_wdata_i[CTL_WAKE_EN];
            kick_en_q <= ctl_wdata_i[CTL_KICK_EN];
            pwr_off_q <= ctl_wdata_i[CTL_PWR_OFF];
        end else if (power_good) begin
            pwr_off_q <= 1'b0;
        end
    end

    // flags: set wins over a software clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wake_flag_q <= 1'b0;
            kick_flag_q <= 1'b0;
        end else begin
            if (alarm_match_i)                            wake_flag_q <= 1'b1;
            else if (flag_wr_i && !flag_wdata_i[FLG_WAKE]) wake_flag_q <= 1'b0;
            if (kick_go)                                  kick_flag_q <= 1'b1;
            else if (flag_wr_i && !flag_wdata_i[FLG_KICK]) kick_flag_q <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        pwr_lvl_o = 1'b0;
        flags_o   = '0;
        flags_o[FLG_WAKE] = wake_flag_q;
        flags_o[FLG_KICK] = kick_flag_q;
        pwr_oe_o  = (st_q == ST_ATTEMPT) || ((st_q == ST_ON) && !pwr_off_q);
        irq_oe_o  = (st_q == ST_ON) &&
                    ((wake_flag_q && wake_en_q) || (kick_flag_q && kick_en_q) || other_irq_i);
    end

    // R6
    expire_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_ATTEMPT && tmo_hit && !supply_ok_i) |=> (!pwr_oe_o && !irq_oe_o));

    // R7
    flags_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_ATTEMPT && tmo_hit && !supply_ok_i && !flag_wr_i)
            |=> ((flags_o & $past(flags_o)) == $past(flags_o)));

    // R8
    good_clears_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (power_good && !ctl_wr_i) |=> (st_q == ST_ON && pwr_oe_o));

    // R10
    shutdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_ON && pwr_off_q && !ctl_wr_i) |=> (st_q == ST_OFF && !pwr_oe_o));

    // R9
    irq_only_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_oe_o) |-> $past(st_q == ST_ON || st_q == ST_ATTEMPT));
endmodule

// File: tb/wake_power_seq_bench.sv
`timescale 1ns/1ps
module wake_power_seq_bench;
    localparam int MINK = 4;
    localparam int TMO  = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b1;
    logic       kick_n = 1'b1;
    logic       alarm = 1'b0;
    logic       sup = 1'b0;
    logic       oirq = 1'b0;
    logic       ctl_wr = 1'b0;
    logic [2:0] ctl_wd = 3'b000;
    logic       flg_wr = 1'b0;
    logic [1:0] flg_wd = 2'b11;
    logic       pwr_oe, pwr_lvl, irq_oe;
    logic [1:0] flags;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    wake_power_seq #(.MIN_KS_TICKS(MINK), .TIMEOUT_TICKS(TMO), .SYNC_STAGES(2)) u_wake_power_seq (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .kick_n_i(kick_n),
        .alarm_match_i(alarm), .supply_ok_i(sup), .other_irq_i(oirq),
        .ctl_wr_i(ctl_wr), .ctl_wdata_i(ctl_wd), .flag_wr_i(flg_wr),
        .flag_wdata_i(flg_wd), .pwr_oe_o(pwr_oe), .pwr_lvl_o(pwr_lvl),
        .irq_oe_o(irq_oe), .flags_o(flags)
    );

    typedef struct packed {
        logic       kn;
        logic       al;
        logic       sp;
        logic       fw;
        logic [7:0] cyc;
        logic       e_pwr;
        logic       e_irq;
        logic [1:0] e_flg;
    } vec_t;

    localparam vec_t VEC [8] = '{
        '{1'b1, 1'b0, 1'b0, 1'b0, 8'd5,  1'b0, 1'b0, 2'b00},
        '{1'b0, 1'b0, 1'b0, 1'b0, 8'd2,  1'b0, 1'b0, 2'b00},
        '{1'b1, 1'b0, 1'b0, 1'b0, 8'd6,  1'b0, 1'b0, 2'b00},
        '{1'b0, 1'b0, 1'b0, 1'b0, 8'd10, 1'b1, 1'b0, 2'b10},
        '{1'b1, 1'b0, 1'b1, 1'b0, 8'd4,  1'b1, 1'b1, 2'b10},
        '{1'b1, 1'b0, 1'b1, 1'b1, 8'd3,  1'b1, 1'b0, 2'b00},
        '{1'b1, 1'b1, 1'b1, 1'b0, 8'd2,  1'b1, 1'b1, 2'b01},
        '{1'b1, 1'b0, 1'b1, 1'b1, 8'd3,  1'b1, 1'b0, 2'b00}
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic ctl_write(input logic [2:0] d);
        @(negedge clk); ctl_wr = 1'b1; ctl_wd = d;
        @(negedge clk); ctl_wr = 1'b0;
    endtask

    task automatic flag_clear();
        @(negedge clk); flg_wr = 1'b1; flg_wd = 2'b00;
        @(negedge clk); flg_wr = 1'b0; flg_wd = 2'b11;
    endtask

    task automatic kick_pulse(input int w);
        @(negedge clk); kick_n = 1'b0;
        repeat (w) @(negedge clk);
        kick_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic alarm_pulse();
        @(negedge clk); alarm = 1'b1;
        @(negedge clk); alarm = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got hung expected finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 pwr_oe", {7'd0, pwr_oe}, 8'd0);
        chk("R1 irq_oe", {7'd0, irq_oe}, 8'd0);
        chk("R1 flags",  {6'd0, flags},  8'd0);
        chk("R5 level",  {7'd0, pwr_lvl}, 8'd0);

        ctl_write(3'b011);

        // table: R2 R3 R5 R8 R9 R11
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            kick_n = VEC[i].kn; alarm = VEC[i].al; sup = VEC[i].sp;
            if (VEC[i].fw) begin flg_wr = 1'b1; flg_wd = 2'b00; end
            @(negedge clk);
            flg_wr = 1'b0; flg_wd = 2'b11;
            repeat (int'(VEC[i].cyc) - 1) @(negedge clk);
            chk($sformatf("R2 R5 R8 R9 vec %0d pwr", i), {7'd0, pwr_oe}, {7'd0, VEC[i].e_pwr});
            chk($sformatf("R3 R9 R11 vec %0d irq", i), {7'd0, irq_oe}, {7'd0, VEC[i].e_irq});
            chk($sformatf("R4 R7 vec %0d flags", i), {6'd0, flags}, {6'd0, VEC[i].e_flg});
        end
        alarm = 1'b0;

        // R10 software power-off
        ctl_write(3'b111);
        chk("R10 pwr drop", {7'd0, pwr_oe}, 8'd0);
        @(negedge clk);
        chk("R10 irq off", {7'd0, irq_oe}, 8'd0);
        sup = 1'b0;
        repeat (3) @(negedge clk);

        // R6 R7 timeout with wake flag latched
        alarm_pulse();
        chk("R5 attempt pwr", {7'd0, pwr_oe}, 8'd1);
        chk("R5 attempt irq", {7'd0, irq_oe}, 8'd0);
        repeat (TMO - 3) @(negedge clk);
        chk("R6 inside window", {7'd0, pwr_oe}, 8'd1);
        repeat (6) @(negedge clk);
        chk("R6 expired pwr", {7'd0, pwr_oe}, 8'd0);
        chk("R6 expired irq", {7'd0, irq_oe}, 8'd0);
        chk("R7 flag latched", {6'd0, flags}, 8'd1);

        // R8 later success, power-off bit cleared
        kick_pulse(MINK + 2);
        chk("R3 kick attempt", {7'd0, pwr_oe}, 8'd1);
        @(negedge clk); sup = 1'b1;
        repeat (3) @(negedge clk);
        chk("R8 on pwr", {7'd0, pwr_oe}, 8'd1);
        chk("R9 on irq", {7'd0, irq_oe}, 8'd1);
        chk("R7 both flags", {6'd0, flags}, 8'd3);
        repeat (10) @(negedge clk);
        chk("R8 off bit cleared", {7'd0, pwr_oe}, 8'd1);

        // R9 other interrupt holds irq
        oirq = 1'b1;
        flag_clear();
        chk("R9 other pending", {7'd0, irq_oe}, 8'd1);
        chk("R7 cleared", {6'd0, flags}, 8'd0);
        oirq = 1'b0;
        @(negedge clk);
        chk("R9 released", {7'd0, irq_oe}, 8'd0);

        // R2 width boundary and tick dependence
        kick_pulse(MINK - 1);
        chk("R2 short ignored", {6'd0, flags}, 8'd0);
        tick = 1'b0;
        kick_pulse(20);
        tick = 1'b1;
        chk("R2 no ticks ignored", {6'd0, flags}, 8'd0);
        kick_pulse(MINK);
        chk("R2 min width", {6'd0, flags}, 8'd2);
        chk("R11 irq while on", {7'd0, irq_oe}, 8'd1);
        flag_clear();

        // R3 R4 disabled enables while off
        ctl_write(3'b100);
        @(negedge clk); sup = 1'b0;
        repeat (3) @(negedge clk);
        kick_pulse(MINK + 2);
        chk("R3 kick disabled flag", {6'd0, flags}, 8'd0);
        chk("R3 kick disabled pwr", {7'd0, pwr_oe}, 8'd0);
        alarm_pulse();
        repeat (2) @(negedge clk);
        chk("R4 wake disabled pwr", {7'd0, pwr_oe}, 8'd0);
        chk("R4 wake flag set", {6'd0, flags}, 8'd1);
        oirq = 1'b1;
        @(negedge clk);
        chk("R9 off no irq", {7'd0, irq_oe}, 8'd0);
        oirq = 1'b0;
        flag_clear();

        // R11 supply already valid in OFF
        ctl_write(3'b010);
        sup = 1'b1;
        repeat (3) @(negedge clk);
        chk("R11 idle off", {7'd0, pwr_oe}, 8'd0);
        kick_pulse(MINK);
        chk("R11 ext pwr", {7'd0, pwr_oe}, 8'd1);
        chk("R11 ext irq", {7'd0, irq_oe}, 8'd1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule